// File: doc/BRIEF.md
# Configuration Byte Write Port

This block sits between a host processor and the configuration store of a square array of programmable logic tiles. The host writes three byte-wide address registers through one register interface: the tile column, the tile row and a selector that picks one logic or routing resource inside that tile. A write to the fourth register, the data register, stores that byte at the addressed location in one configuration cycle and raises a one-cycle strobe. The host has no path to read the store back.

Every commit replaces the whole byte. Resources that share a byte therefore lose any bits the new value does not repeat, so software must build each byte in full before writing it. The address registers keep their values between commits. A run of data writes thus lands on the same location, and the last one wins.

A clear sequence zeroes the whole store, one location per cycle, before a fresh setup. While it runs, a busy flag is high and data writes are dropped. Address writes still load. Commits aimed outside the array, whether by column, row or resource, are discarded. The stored contents are visible on a side observation port that the enclosing design uses to drive the tiles.

Top module: `cfg_write_port`

## Requirements
- R1: After reset, busy and cfg_strobe are 0 and all three address registers hold 0, so a data write with no prior address write stores at column 0, row 0, resource 0.
- R2: A register write with reg_sel = 0 loads the column, 1 loads the row and 2 loads the resource selector. None of these changes the store or raises cfg_strobe.
- R3: A register write with reg_sel = 3 and an in-range address stores reg_wdata at the addressed location on that clock edge. cfg_strobe is high for exactly the following cycle. The location index is (row*GRID + column)*RES_PER_TILE + resource.
- R4: The address registers keep their values across commits, so repeated data writes go to the same location, the last value remains, and no other location changes.
- R5: A commit replaces all eight bits of the addressed byte, whatever value was there before.
- R6: A data write whose column or row is GRID or greater changes no location and raises no strobe.
- R7: A data write whose resource selector is RES_PER_TILE or greater changes no location and raises no strobe.
- R8: A clear_start pulse while idle raises busy on the next cycle. busy stays high for exactly GRID*GRID*RES_PER_TILE cycles, and afterwards every location reads 0.
- R9: While busy is high, data writes are dropped with no strobe and no store change. Address register writes still take effect.
- R10: A clear_start pulse while busy is high is ignored and does not lengthen the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Host register write enable |
| reg_sel | input | 2 | Register select: 0 column, 1 row, 2 resource, 3 data (commit) |
| reg_wdata | input | 8 | Host write byte |
| clear_start | input | 1 | Starts the zeroing sweep when idle |
| busy | output | 1 | High while the sweep runs |
| cfg_strobe | output | 1 | One-cycle pulse after each accepted commit |
| obs_col | input | 8 | Observation column |
| obs_row | input | 8 | Observation row |
| obs_res | input | 8 | Observation resource selector |
| obs_data | output | 8 | Stored byte at the observation address (0 when out of range) |

## Verification
The hardest case to reach is a data write that arrives in the middle of a sweep. The sweep has already passed the addressed location, so a commit that wrongly got through would survive the sweep. The bench sets the address to location 0 before starting a clear and issues the data write many cycles into the sweep. It also loads a new column during the sweep and fires a second clear_start partway through. It then checks the whole store, the strobe, the sweep length, and that the next commit lands at the column loaded during the sweep.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  // Host register selector codes
  typedef enum logic [1:0] {
    SEL_COL  = 2'd0,
    SEL_ROW  = 2'd1,
    SEL_RES  = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

  // Linear location of a (column,row,resource) triple in the store
  function automatic int unsigned flat_index(input logic [7:0] col,
                                             input logic [7:0] row,
                                             input logic [7:0] res,
                                             input int unsigned grid,
                                             input int unsigned rpt);
    return ((32'(row) * grid) + 32'(col)) * rpt + 32'(res);
  endfunction

  // True when the triple addresses a real location
  function automatic logic addr_in_range(input logic [7:0] col,
                                         input logic [7:0] row,
                                         input logic [7:0] res,
                                         input int unsigned grid,
                                         input int unsigned rpt);
    return (32'(col) < grid) && (32'(row) < grid) && (32'(res) < rpt);
  endfunction

endpackage

// File: rtl/cfg_addr_regs.sv
module cfg_addr_regs
  import cfgport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] sel,
  input  logic [7:0] wdata,
  output logic [7:0] col_q,
  output logic [7:0] row_q,
  output logic [7:0] res_q,
  output logic       data_hit
);
  reg_sel_e sel_e;
  assign sel_e    = reg_sel_e'(sel);
  assign data_hit = wr_en && (sel_e == SEL_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
      res_q <= '0;
    end else if (wr_en) begin
      case (sel_e)
        SEL_COL: col_q <= wdata;
        SEL_ROW: row_q <= wdata;
        SEL_RES: res_q <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_clear_seq.sv
module cfg_clear_seq #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned IDXW  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic            sweep_we,
  output logic [IDXW-1:0] sweep_idx
);
  logic            busy_q;
  logic [IDXW-1:0] ptr_q;
  logic            at_last;

  assign at_last   = (ptr_q == IDXW'(DEPTH - 1));
  assign busy      = busy_q;
  assign sweep_we  = busy_q;
  assign sweep_idx = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else if (busy_q) begin
      ptr_q <= ptr_q + 1'b1;
      if (at_last) busy_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
    end
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned IDXW  = 6
) (
  input  logic            clk,
  input  logic            host_we,
  input  logic [IDXW-1:0] host_idx,
  input  logic [7:0]      host_data,
  input  logic            sweep_we,
  input  logic [IDXW-1:0] sweep_idx,
  input  logic [IDXW-1:0] obs_idx,
  output logic [7:0]      obs_data
);
  logic [7:0]      mem [DEPTH];
  logic            we;
  logic [IDXW-1:0] widx;
  logic [7:0]      wval;

  // The sweep owns the single write port whenever it runs
  always_comb begin
    we   = sweep_we || host_we;
    widx = sweep_we ? sweep_idx : host_idx;
    wval = sweep_we ? 8'h00 : host_data;
  end

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wval;
  end

  assign obs_data = mem[obs_idx];
endmodule

// File: rtl/cfg_write_port.sv
module cfg_write_port
  import cfgport_pkg::*;
#(
  parameter int unsigned GRID         = 8,
  parameter int unsigned RES_PER_TILE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr_en,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  input  logic       clear_start,
  output logic       busy,
  output logic       cfg_strobe,
  input  logic [7:0] obs_col,
  input  logic [7:0] obs_row,
  input  logic [7:0] obs_res,
  output logic [7:0] obs_data
);
  localparam int unsigned DEPTH = GRID * GRID * RES_PER_TILE;
  localparam int unsigned IDXW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]      col_q, row_q, res_q;
  logic            data_hit;
  logic            addr_ok;
  logic            commit_fire;
  logic [IDXW-1:0] host_idx;
  logic            sweep_we;
  logic [IDXW-1:0] sweep_idx;
  logic            obs_ok;
  logic [IDXW-1:0] obs_idx;
  logic [7:0]      obs_raw;
  logic            strobe_q;

  cfg_addr_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .sel      (reg_sel),
    .wdata    (reg_wdata),
    .col_q    (col_q),
    .row_q    (row_q),
    .res_q    (res_q),
    .data_hit (data_hit)
  );

  cfg_clear_seq #(.DEPTH(DEPTH), .IDXW(IDXW)) u_clear (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (clear_start),
    .busy      (busy),
    .sweep_we  (sweep_we),
    .sweep_idx (sweep_idx)
  );

  assign addr_ok     = addr_in_range(col_q, row_q, res_q, GRID, RES_PER_TILE);
  assign commit_fire = data_hit && !busy && addr_ok;
  assign host_idx    = IDXW'(flat_index(col_q, row_q, res_q, GRID, RES_PER_TILE));

  assign obs_ok  = addr_in_range(obs_col, obs_row, obs_res, GRID, RES_PER_TILE);
  assign obs_idx = obs_ok ? IDXW'(flat_index(obs_col, obs_row, obs_res, GRID, RES_PER_TILE))
                          : '0;

  cfg_store #(.DEPTH(DEPTH), .IDXW(IDXW)) u_store (
    .clk       (clk),
    .host_we   (commit_fire),
    .host_idx  (host_idx),
    .host_data (reg_wdata),
    .sweep_we  (sweep_we),
    .sweep_idx (sweep_idx),
    .obs_idx   (obs_idx),
    .obs_data  (obs_raw)
  );

  assign obs_data = obs_ok ? obs_raw : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= commit_fire;
  end
  assign cfg_strobe = strobe_q;
endmodule

// File: rtl/cfg_write_port_chk.sv
module cfg_write_port_chk #(
  parameter int unsigned DEPTH = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr_en,
  input logic [1:0] reg_sel,
  input logic       clear_start,
  input logic       busy,
  input logic       cfg_strobe,
  input logic       commit_fire,
  input logic       sweep_we,
  input logic [7:0] col_q
);
  logic [31:0] busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= '0;
  end

  assert_strobe_after_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_strobe |-> $past(reg_wr_en && reg_sel == 2'd3 && !busy));

  assert_busy_drops_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_sel == 2'd3 && busy) |=> !cfg_strobe);

  assert_one_writer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_fire, sweep_we}));

  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(clear_start));

  assert_sweep_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= DEPTH);

  assert_col_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_sel == 2'd0) |=> $stable(col_q));
endmodule

bind cfg_write_port cfg_write_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_sel     (reg_sel),
  .clear_start (clear_start),
  .busy        (busy),
  .cfg_strobe  (cfg_strobe),
  .commit_fire (commit_fire),
  .sweep_we    (sweep_we),
  .col_q       (col_q)
);

// File: tb/tb_cfg_write_port.sv
`timescale 1ns/1ps
module tb_cfg_write_port;
  localparam int G  = 4;
  localparam int RP = 4;
  localparam int N  = G * G * RP;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic       clear_start = 1'b0;
  logic       busy, cfg_strobe;
  logic [7:0] obs_col = 8'h00, obs_row = 8'h00, obs_res = 8'h00;
  logic [7:0] obs_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [N];

  always #2 clk = ~clk;

  cfg_write_port #(.GRID(G), .RES_PER_TILE(RP)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .clear_start(clear_start), .busy(busy),
    .cfg_strobe(cfg_strobe), .obs_col(obs_col), .obs_row(obs_row),
    .obs_res(obs_res), .obs_data(obs_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic set_addr(input int c, input int r, input int z);
    host_write(2'd0, 8'(c));
    host_write(2'd1, 8'(r));
    host_write(2'd2, 8'(z));
  endtask

  function automatic int loc(input int c, input int r, input int z);
    return r * G * RP + c * RP + z;
  endfunction

  task automatic verify_all(input string req);
    for (int r = 0; r < G; r++)
      for (int c = 0; c < G; c++)
        for (int z = 0; z < RP; z++) begin
          obs_col = 8'(c); obs_row = 8'(r); obs_res = 8'(z);
          #0.5;
          chk(req, int'(obs_data), int'(model[loc(c, r, z)]));
        end
  endtask

  // Pulses clear_start and returns the number of busy cycles
  task automatic run_clear(input bit extra_start, output int cnt);
    @(negedge clk); clear_start = 1'b1;
    @(negedge clk); clear_start = 1'b0;
    cnt = 0;
    while (busy && cnt < 10 * N) begin
      cnt++;
      if (extra_start && cnt == 5) clear_start = 1'b1;
      @(negedge clk);
      clear_start = 1'b0;
    end
    for (int i = 0; i < N; i++) model[i] = 8'h00;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 strobe after reset", int'(cfg_strobe), 0);

    // R8: clear sweep length and result
    run_clear(1'b0, cnt);
    chk("R8 busy length", cnt, N);
    verify_all("R8 zero after clear");

    // R1: address registers are zero after reset
    host_write(2'd3, 8'h3C);
    chk("R1 strobe on commit", int'(cfg_strobe), 1);
    model[0] = 8'h3C;
    verify_all("R1 default address");

    // R2: an address write raises no strobe
    host_write(2'd1, 8'h02);
    chk("R2 no strobe on address write", int'(cfg_strobe), 0);

    // R3: exhaustive fill with a computed pattern
    for (int r = 0; r < G; r++)
      for (int c = 0; c < G; c++)
        for (int z = 0; z < RP; z++) begin
          logic [7:0] v;
          v = 8'((c * 37 + r * 11 + z * 5 + 3) & 255);
          set_addr(c, r, z);
          host_write(2'd3, v);
          chk("R3 strobe per commit", int'(cfg_strobe), 1);
          @(negedge clk);
          chk("R3 strobe single cycle", int'(cfg_strobe), 0);
          model[loc(c, r, z)] = v;
        end
    verify_all("R3 exhaustive fill");

    // R4: repeated data writes go to the same place
    set_addr(2, 3, 1);
    host_write(2'd3, 8'h11);
    host_write(2'd3, 8'h22);
    host_write(2'd3, 8'h33);
    chk("R4 repeated commit strobe", int'(cfg_strobe), 1);
    model[loc(2, 3, 1)] = 8'h33;
    verify_all("R4 address held");

    // R5: whole byte replaced
    host_write(2'd3, 8'hF0);
    host_write(2'd3, 8'h0F);
    model[loc(2, 3, 1)] = 8'h0F;
    verify_all("R5 byte replaced");

    // R6: column or row out of range
    set_addr(G, 0, 0);
    host_write(2'd3, 8'h77);
    chk("R6 no strobe column", int'(cfg_strobe), 0);
    set_addr(1, 200, 0);
    host_write(2'd3, 8'h78);
    chk("R6 no strobe row", int'(cfg_strobe), 0);
    verify_all("R6 store unchanged");

    // R7: resource out of range
    set_addr(1, 1, RP);
    host_write(2'd3, 8'h79);
    chk("R7 no strobe resource", int'(cfg_strobe), 0);
    verify_all("R7 store unchanged");

    // R9: data write during sweep dropped, address write kept
    set_addr(0, 0, 0);
    @(negedge clk); clear_start = 1'b1;
    @(negedge clk); clear_start = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 busy mid sweep", int'(busy), 1);
    host_write(2'd3, 8'hAA);
    chk("R9 no strobe while busy", int'(cfg_strobe), 0);
    host_write(2'd0, 8'h01);
    while (busy) @(negedge clk);
    for (int i = 0; i < N; i++) model[i] = 8'h00;
    verify_all("R9 dropped write");
    host_write(2'd3, 8'h5C);
    chk("R9 commit after sweep", int'(cfg_strobe), 1);
    model[loc(1, 0, 0)] = 8'h5C;
    verify_all("R9 column loaded while busy");

    // R10: extra start during sweep ignored
    run_clear(1'b1, cnt);
    chk("R10 sweep not extended", cnt, N);
    verify_all("R10 zero after clear");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule